// File: doc/BRIEF.md
# Dual-Rail Dejitter Elastic Buffer

This block sits in one receive channel between a line interface and the terminal side. Dual-rail line symbols (a positive-rail bit and a negative-rail bit per symbol) arrive with a jittery recovered clock. They leave with a smoothed clock produced elsewhere. The buffer absorbs the phase difference between the two clocks. It can hold 16 or 32 symbols, and it reports through a sticky limit flag when it comes close to running dry or filling up.

The block runs on one fast system clock. The recovered clock and the smoothed clock enter as plain lines (`wr_line`, `rd_line`) and are sampled by that clock. Each side has its own polarity select, which picks whether a rising or a falling transition of that line counts as a strobe. Line data cannot be stalled, so there is no back-pressure on either side. A write into a full buffer or a read from an empty one re-centres the pointers and raises the flag; nothing is dropped silently. In bypass mode the input rails reach the outputs combinationally and the store is frozen.

All inputs are synchronous to `clk`, and so is the active-low reset. Reset (or an automatic re-centre) loads the depth chosen by `deep_sel`, places the read pointer half that depth behind the write pointer, and marks the store half full.

Top module: `dejitter_buf`

## Requirements
- R1: When the buffer was last reset or re-centred with `deep_sel` low it holds 16 symbols; with `deep_sel` high it holds 32. After reset the fill level is half the depth, so depth/2 writes without reads bring it to full.
- R2: Each slot stores one positive-rail and one negative-rail bit. Reads return symbols in write order, delayed by depth/2 symbols after reset. The first depth/2 reads after reset return zero on both rails.
- R3: `lim_flag` rises one clock after the fill level becomes less than or equal to 2, or greater than or equal to depth-2.
- R4: `lim_flag` stays set after the fill level leaves the band. A high level on `lim_clr` clears it only when the fill level is outside the band; inside the band it stays set.
- R5: `stat_clr` clears `lim_flag` under the same rule as `lim_clr`.
- R6: Reset clears `lim_flag`, drives both output rails to zero and re-centres the store.
- R7: While `bypass` is high, `out_pos`/`out_neg` equal `in_pos`/`in_neg` in the same cycle. Strobes are ignored, so the stored contents and pointers are unchanged when bypass ends.
- R8: A strobe is a rising transition of its line when the side's polarity select (`wr_rise`/`rd_rise`) is 1, and a falling transition when it is 0. Data is captured from the rails in the system-clock cycle in which the transition is first seen.
- R9: A change of `deep_sel` takes effect only at the next reset or re-centre.
- R10: A write without a read into a full buffer, or a read from an empty buffer, discards that access, re-centres the store to half of the depth now selected, and sets `lim_flag`.
- R11: The output rails hold their last value while no read strobe occurs, including across an underflow re-centre.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock sampling all lines |
| rst_n | input | 1 | Synchronous active-low reset and re-centre |
| wr_line | input | 1 | Recovered (jittery) write clock line |
| rd_line | input | 1 | Smoothed read clock line |
| wr_rise | input | 1 | 1: write on rising transition, 0: on falling |
| rd_rise | input | 1 | 1: read on rising transition, 0: on falling |
| in_pos | input | 1 | Positive-rail input data |
| in_neg | input | 1 | Negative-rail input data |
| deep_sel | input | 1 | Depth select, 0: 16 slots, 1: 32 slots |
| bypass | input | 1 | High: rails pass straight through |
| lim_clr | input | 1 | Clear request for the limit flag |
| stat_clr | input | 1 | Status-read clear for the limit flag |
| out_pos | output | 1 | Positive-rail output data |
| out_neg | output | 1 | Negative-rail output data |
| lim_flag | output | 1 | Sticky near-empty/near-full flag |

## Verification
A strobe becomes visible on the output rails at the system-clock edge where its line transition is first sampled. The limit flag follows the fill level one edge later, and a re-centre shows up on the flag two edges after the offending strobe. Bypass output is combinational and is due within the same cycle. The bench drives each strobe for one cycle, returns the line to idle in the next, and samples at the falling clock edge after that second cycle, when both data and flag have settled. Bypass outputs are sampled shortly after the inputs change. Fill-level results are derived arithmetically from the count of writes and reads since the last re-centre.

// File: rtl/dejit_pkg.sv
package dejit_pkg;
  typedef struct packed {
    logic pos;
    logic neg;
  } rail_pair_t;
endpackage

// File: rtl/dejit_edge_pick.sv
// Turns a sampled clock line into a one-cycle strobe on the chosen transition.
module dejit_edge_pick (
  input  logic clk,
  input  logic line_in,
  input  logic rise_mode,
  output logic fire
);
  logic line_q;

  always_ff @(posedge clk) line_q <= line_in;

  assign fire = rise_mode ? (line_in & ~line_q) : (~line_in & line_q);
endmodule

// File: rtl/dejit_store.sv
// Circular symbol store with explicit fill count and re-centre on slip.
module dejit_store
  import dejit_pkg::*;
#(
  parameter int DEPTH_MAX = 32,
  parameter int DEPTH_MIN = 16,
  localparam int PTR_W = $clog2(DEPTH_MAX),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_evt,
  input  logic             rd_evt,
  input  logic             freeze,
  input  logic             deep_sel,
  input  rail_pair_t       din,
  output rail_pair_t       dout,
  output logic [CNT_W-1:0] fill,
  output logic [CNT_W-1:0] depth,
  output logic             slip
);
  logic [CNT_W-1:0] sel_depth, sel_half;
  logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_ptr_nx, rd_ptr_nx, last_idx;
  logic [CNT_W-1:0] fill_q, depth_q;
  logic             overflow, underflow, slip_now, slip_q;
  rail_pair_t       mem [DEPTH_MAX];
  rail_pair_t       dout_q;

  assign sel_depth = deep_sel ? CNT_W'(DEPTH_MAX) : CNT_W'(DEPTH_MIN);
  assign sel_half  = sel_depth >> 1;
  assign last_idx  = PTR_W'(depth_q - 1'b1);
  assign wr_ptr_nx = (wr_ptr == last_idx) ? '0 : wr_ptr + 1'b1;
  assign rd_ptr_nx = (rd_ptr == last_idx) ? '0 : rd_ptr + 1'b1;

  assign overflow  = wr_evt & ~rd_evt & (fill_q == depth_q);
  assign underflow = rd_evt & (fill_q == '0);
  assign slip_now  = ~freeze & (overflow | underflow);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth_q <= sel_depth;
      fill_q  <= sel_half;
      wr_ptr  <= PTR_W'(sel_half);
      rd_ptr  <= '0;
      dout_q  <= '0;
      slip_q  <= 1'b0;
      for (int i = 0; i < DEPTH_MAX; i++) mem[i] <= '0;
    end else begin
      slip_q <= slip_now;
      if (slip_now) begin
        depth_q <= sel_depth;
        fill_q  <= sel_half;
        wr_ptr  <= PTR_W'(sel_half);
        rd_ptr  <= '0;
      end else if (!freeze) begin
        if (wr_evt) begin
          mem[wr_ptr] <= din;
          wr_ptr      <= wr_ptr_nx;
        end
        if (rd_evt) begin
          dout_q <= mem[rd_ptr];
          rd_ptr <= rd_ptr_nx;
        end
        fill_q <= fill_q + CNT_W'(wr_evt) - CNT_W'(rd_evt);
      end
    end
  end

  assign dout  = dout_q;
  assign fill  = fill_q;
  assign depth = depth_q;
  assign slip  = slip_q;
endmodule

// File: rtl/dejit_limit.sv
// Sticky flag for fill level near either end of the store.
module dejit_limit #(
  parameter int CNT_W = 6,
  parameter int BAND  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] fill,
  input  logic [CNT_W-1:0] depth,
  input  logic             slip,
  input  logic             clr,
  output logic             flag
);
  logic near;

  assign near = (fill <= CNT_W'(BAND)) || (fill >= depth - CNT_W'(BAND));

  always_ff @(posedge clk) begin
    if (!rst_n)             flag <= 1'b0;
    else if (slip || near)  flag <= 1'b1;
    else if (clr)           flag <= 1'b0;
  end
endmodule

// File: rtl/dejitter_buf.sv
module dejitter_buf
  import dejit_pkg::*;
#(
  parameter int DEPTH_MAX  = 32,
  parameter int DEPTH_MIN  = 16,
  parameter int LIMIT_BAND = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_line,
  input  logic rd_line,
  input  logic wr_rise,
  input  logic rd_rise,
  input  logic in_pos,
  input  logic in_neg,
  input  logic deep_sel,
  input  logic bypass,
  input  logic lim_clr,
  input  logic stat_clr,
  output logic out_pos,
  output logic out_neg,
  output logic lim_flag
);
  localparam int CNT_W = $clog2(DEPTH_MAX) + 1;

  logic             wr_evt, rd_evt, slip;
  logic [CNT_W-1:0] fill_cnt, cur_depth;
  rail_pair_t       in_sym, buf_out;

  assign in_sym = '{pos: in_pos, neg: in_neg};

  dejit_edge_pick u_wr_edge (.clk(clk), .line_in(wr_line), .rise_mode(wr_rise), .fire(wr_evt));
  dejit_edge_pick u_rd_edge (.clk(clk), .line_in(rd_line), .rise_mode(rd_rise), .fire(rd_evt));

  dejit_store #(.DEPTH_MAX(DEPTH_MAX), .DEPTH_MIN(DEPTH_MIN)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .rd_evt(rd_evt), .freeze(bypass),
    .deep_sel(deep_sel), .din(in_sym), .dout(buf_out), .fill(fill_cnt),
    .depth(cur_depth), .slip(slip)
  );

  dejit_limit #(.CNT_W(CNT_W), .BAND(LIMIT_BAND)) u_limit (
    .clk(clk), .rst_n(rst_n), .fill(fill_cnt), .depth(cur_depth), .slip(slip),
    .clr(lim_clr | stat_clr), .flag(lim_flag)
  );

  assign out_pos = bypass ? in_pos : buf_out.pos;
  assign out_neg = bypass ? in_neg : buf_out.neg;
endmodule

// File: rtl/dejit_checker.sv
module dejit_checker #(
  parameter int DEPTH_MAX  = 32,
  parameter int DEPTH_MIN  = 16,
  parameter int LIMIT_BAND = 2,
  localparam int CNT_W = $clog2(DEPTH_MAX) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bypass,
  input logic             wr_evt,
  input logic             rd_evt,
  input logic [CNT_W-1:0] fill,
  input logic [CNT_W-1:0] depth,
  input logic [1:0]       held,
  input logic             lim_flag
);
  assert_depth_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (depth == CNT_W'(DEPTH_MIN) || depth == CNT_W'(DEPTH_MAX)) && fill <= depth);

  assert_band_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill <= CNT_W'(LIMIT_BAND) || fill >= depth - CNT_W'(LIMIT_BAND)) |=> lim_flag);

  assert_reset_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !lim_flag);

  assert_bypass_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |=> $stable(fill) && $stable(held));

  assert_overflow_slip_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && wr_evt && !rd_evt && fill == depth) |=> (fill == (depth >> 1)) ##1 lim_flag);

  assert_underflow_slip_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && rd_evt && fill == '0) |=> (fill == (depth >> 1)) ##1 lim_flag);

  assert_output_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_evt |=> $stable(held));
endmodule

bind dejitter_buf dejit_checker #(
  .DEPTH_MAX(DEPTH_MAX), .DEPTH_MIN(DEPTH_MIN), .LIMIT_BAND(LIMIT_BAND)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bypass(bypass), .wr_evt(wr_evt), .rd_evt(rd_evt),
  .fill(fill_cnt), .depth(cur_depth), .held(buf_out), .lim_flag(lim_flag)
);

// File: tb/test_dejitter_buf.sv
`timescale 1ns/1ps
module test_dejitter_buf;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_line = 1'b0, rd_line = 1'b0, wr_rise = 1'b1, rd_rise = 1'b1;
  logic in_pos = 1'b0, in_neg = 1'b0, deep_sel = 1'b0, bypass = 1'b0;
  logic lim_clr = 1'b0, stat_clr = 1'b0;
  logic out_pos, out_neg, lim_flag;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [1:0] q[$];

  always #2 clk = ~clk;

  dejitter_buf i_dejitter_buf (
    .clk(clk), .rst_n(rst_n), .wr_line(wr_line), .rd_line(rd_line), .wr_rise(wr_rise),
    .rd_rise(rd_rise), .in_pos(in_pos), .in_neg(in_neg), .deep_sel(deep_sel),
    .bypass(bypass), .lim_clr(lim_clr), .stat_clr(stat_clr), .out_pos(out_pos),
    .out_neg(out_neg), .lim_flag(lim_flag)
  );

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cyc);
      report();
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic do_reset(input logic d, input logic wr_r, input logic rd_r);
    @(negedge clk);
    rst_n = 1'b0; deep_sel = d; wr_rise = wr_r; rd_rise = rd_r;
    wr_line = ~wr_r; rd_line = ~rd_r; bypass = 1'b0; lim_clr = 1'b0; stat_clr = 1'b0;
    cycles(3);
    rst_n = 1'b1;
    cycles(1);
    q.delete();
    for (int i = 0; i < (d ? 16 : 8); i++) q.push_back(2'b00);
  endtask

  // strobe cycle with rails p/n, then idle cycle with inverted rails
  task automatic tick(input bit w, input bit r, input bit p, input bit n);
    in_pos = p; in_neg = n;
    if (w) wr_line = wr_rise;
    if (r) rd_line = rd_rise;
    cycles(1);
    in_pos = ~p; in_neg = ~n;
    wr_line = ~wr_rise; rd_line = ~rd_rise;
    cycles(1);
  endtask

  task automatic pulse_clr(input bit use_stat);
    if (use_stat) stat_clr = 1'b1; else lim_clr = 1'b1;
    cycles(1);
    stat_clr = 1'b0; lim_clr = 1'b0;
    cycles(1);
  endtask

  initial begin
    logic [1:0] held, sym;
    int h, dd;

    // R2, R8, R11: streaming over depth and both polarity selects
    for (int cfg = 0; cfg < 8; cfg++) begin
      do_reset(cfg[2], cfg[0], cfg[1]);
      chk("R6 reset rails", {out_pos, out_neg}, 2'b00);
      chk("R6 reset flag", {1'b0, lim_flag}, 2'b00);
      for (int i = 0; i < 40; i++) begin
        sym = {i[0] ^ i[3], i[1] | i[2]};
        tick(1, 1, sym[1], sym[0]);
        q.push_back(sym);
        chk("R2 R8 stream data", {out_pos, out_neg}, q.pop_front());
      end
      held = {out_pos, out_neg};
      tick(1, 0, 1'b1, 1'b0);
      q.push_back(2'b10);
      chk("R11 hold without read", {out_pos, out_neg}, held);
      tick(0, 1, 1'b0, 1'b0);
      chk("R2 read after write-only", {out_pos, out_neg}, q.pop_front());
    end

    // R1, R3, R4, R5, R10, R11: band sweep, clears, overflow and underflow
    for (int d = 0; d < 2; d++) begin
      do_reset(d[0], 1'b1, 1'b1);
      h = d ? 16 : 8; dd = 2 * h;
      for (int k = 1; k <= h - 2; k++) begin
        tick(1, 0, k[0], k[1]);
        chk("R1 R3 upper band", {1'b0, lim_flag}, {1'b0, (h + k >= dd - 2)});
      end
      pulse_clr(0);
      chk("R4 clear ignored in band", {1'b0, lim_flag}, 2'b01);
      tick(0, 1, 1'b0, 1'b0);
      chk("R2 first read zero", {out_pos, out_neg}, 2'b00);
      chk("R4 sticky outside band", {1'b0, lim_flag}, 2'b01);
      pulse_clr(0);
      chk("R4 clear outside band", {1'b0, lim_flag}, 2'b00);
      for (int k = 0; k < 3; k++) tick(1, 0, 1'b1, 1'b1);
      chk("R3 full sets flag", {1'b0, lim_flag}, 2'b01);
      pulse_clr(1);
      chk("R5 status clear ignored in band", {1'b0, lim_flag}, 2'b01);
      tick(1, 0, 1'b1, 1'b1);
      chk("R10 overflow flag", {1'b0, lim_flag}, 2'b01);
      pulse_clr(1);
      chk("R5 status clear after recentre", {1'b0, lim_flag}, 2'b00);
      for (int k = 1; k <= h; k++) begin
        tick(0, 1, 1'b0, 1'b0);
        chk("R3 R10 lower band", {1'b0, lim_flag}, {1'b0, (h - k <= 2)});
      end
      held = {out_pos, out_neg};
      pulse_clr(0);
      tick(0, 1, 1'b0, 1'b0);
      chk("R11 hold on underflow", {out_pos, out_neg}, held);
      chk("R10 underflow flag", {1'b0, lim_flag}, 2'b01);
      pulse_clr(0);
      chk("R10 underflow recentred", {1'b0, lim_flag}, 2'b00);
    end

    // R9: depth change only at re-centre
    do_reset(1'b0, 1'b1, 1'b1);
    deep_sel = 1'b1;
    for (int k = 0; k < 6; k++) tick(1, 0, 1'b0, 1'b1);
    chk("R9 old depth kept", {1'b0, lim_flag}, 2'b01);
    for (int k = 0; k < 3; k++) tick(1, 0, 1'b0, 1'b1);
    pulse_clr(0);
    chk("R9 overflow recentred", {1'b0, lim_flag}, 2'b00);
    for (int k = 1; k <= 14; k++) begin
      tick(0, 1, 1'b0, 1'b0);
      chk("R9 new depth band", {1'b0, lim_flag}, {1'b0, (k >= 14)});
    end

    // R7: bypass
    do_reset(1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 5; i++) begin
      tick(1, 1, i[0], i[1]);
      q.push_back({i[0], i[1]});
      chk("R2 pre-bypass data", {out_pos, out_neg}, q.pop_front());
    end
    held = {out_pos, out_neg};
    bypass = 1'b1;
    for (int v = 0; v < 4; v++) begin
      in_pos = v[0]; in_neg = v[1];
      wr_line = ~wr_line; rd_line = ~rd_line;
      #1;
      chk("R7 bypass passthrough", {out_pos, out_neg}, {v[0], v[1]});
      cycles(1);
    end
    wr_line = ~wr_rise; rd_line = ~rd_rise;
    cycles(1);
    bypass = 1'b0;
    #1;
    chk("R7 output after bypass", {out_pos, out_neg}, held);
    cycles(1);
    tick(1, 1, 1'b1, 1'b1);
    q.push_back(2'b11);
    chk("R7 store untouched", {out_pos, out_neg}, q.pop_front());
    chk("R7 flag untouched", {1'b0, lim_flag}, 2'b00);

    report();
    $finish;
  end
endmodule